// File: doc/BRIEF.md
# Reloadable Down-Counting Interrupt Timer

A small timer peripheral with a parameterised number of identical channels behind a simple word-wide register bus. Each channel has three registers: control, fixed count and running count. The running counter steps down by one on each tick from a source picked in the control register. When it steps from one to zero it sets a sticky pending flag. The flag drives that channel's interrupt line when its enable bit is set.

Two control bits decide how a channel behaves. The reload bit makes the counter restart from the fixed count on the tick after it reaches zero. Without reload, the counter parks at zero. The update bit makes any write of the fixed count copy the value into the running counter on the same clock edge. With update set and reload clear, a channel works as a one-shot event timer: software writes the delay and waits for the interrupt. With reload set and a fixed count of all ones, it works as a free-running reference, and software inverts its value to obtain a rising time base.

Top module: `dtimer_top`

## Requirements
- R1: After reset every control, fixed-count and running-count register reads 0 and every `irq` bit is 0.
- R2: Channel n decodes control at 0x20+n*0x40, running count at 0x30+n*0x40 and fixed count at 0x40+n*0x40. Control fields are tick select at bits 3:0, reload at bit 6, update at bit 7, interrupt enable at bit 14 and pending flag at bit 15. All other control bits read 0, and any unmapped address reads 0.
- R3: The running-count register is read-only, so a bus write to it leaves the counter unchanged.
- R4: A fixed-count write with update=1 loads the written value into the running counter on the same edge. With update=0, the running counter is not touched.
- R5: The counter decrements by one per selected tick. Select 0xF ticks every clock and 0xB ticks on `slow_tick`. Select codes 0 to N_EXT-1 tick on `ext_tick[code]`. Every other code stops the counter.
- R6: The pending flag is set on the edge where the counter steps from 1 to 0, and it stays set until software clears it.
- R7: With reload=0, a counter at zero stays at zero.
- R8: With reload=1, a tick while the counter is at zero loads the fixed count, so one period lasts fixed+1 ticks.
- R9: Writing control with bit 15 = 0 clears the flag, and writing 1 there never sets it. A flag set by the counter on the same edge as a clearing write wins.
- R10: `irq[n]` is high exactly when channel n's flag and interrupt enable are both set.
- R11: Channels are independent: a write to, or tick of, one channel does not change another.
- R12: A loading fixed-count write takes priority over a tick on the same edge, so the counter holds the written value rather than that value minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_tick | input | N_EXT | External tick-enable inputs |
| slow_tick | input | 1 | Slow tick enable |
| irq | output | NCH | Per-channel interrupt request |

## Verification
The bench targets these corner cases:

- **The 1-to-0 step.** A design that raised the flag at the wrong step would interrupt one tick early or late.
- **A zero count with and without reload.** Getting this wrong gives a counter that wraps to all ones, or one that never restarts.
- **A clearing control write on the same edge as the flag-setting tick.** A design that let the clear win would lose an event.
- **A loading fixed-count write on the same edge as a tick.** A design that let the tick win would shorten the programmed delay by one.
- **Unused and external tick codes, the read-only counter, and a second channel.** These catch wrong source muxing, a writable counter, and address decode that crosses between channels.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  localparam int BUS_W     = 32;
  localparam int CTRL_OFS  = 'h20;
  localparam int RUN_OFS   = 'h30;
  localparam int FIX_OFS   = 'h40;
  localparam int CH_STRIDE = 'h40;

  localparam logic [3:0] SEL_ALWAYS = 4'hF;
  localparam logic [3:0] SEL_SLOW   = 4'hB;

  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IRQEN  = 14;
  localparam int B_FLAG   = 15;

  typedef struct packed {
    logic       flag;
    logic       irq_en;
    logic       update;
    logic       reload;
    logic [3:0] sel;
  } ctrl_t;

  function automatic logic [BUS_W-1:0] ctrl_pack(ctrl_t c);
    logic [BUS_W-1:0] w;
    w           = '0;
    w[3:0]      = c.sel;
    w[B_RELOAD] = c.reload;
    w[B_UPDATE] = c.update;
    w[B_IRQEN]  = c.irq_en;
    w[B_FLAG]   = c.flag;
    return w;
  endfunction

endpackage

// File: rtl/dtimer_tick_sel.sv
module dtimer_tick_sel #(
  parameter int N_EXT = 4
) (
  input  logic [3:0]       sel,
  input  logic [N_EXT-1:0] ext_tick,
  input  logic             slow_tick,
  output logic             tick
);
  import dtimer_pkg::*;

  always_comb begin
    tick = 1'b0;
    if (sel == SEL_ALWAYS) begin
      tick = 1'b1;
    end else if (sel == SEL_SLOW) begin
      tick = slow_tick;
    end else begin
      for (int i = 0; i < N_EXT; i++) begin
        if (sel == 4'(i)) tick = ext_tick[i];
      end
    end
  end

endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan #(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic                fix_we,
  input  logic [15:0]         ctrl_wdata,
  input  logic [DW-1:0]       fix_wdata,
  input  logic                tick,
  output dtimer_pkg::ctrl_t   ctrl,
  output logic [DW-1:0]       run_cnt,
  output logic [DW-1:0]       fix_cnt,
  output logic                load,
  output logic                irq
);
  import dtimer_pkg::*;

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] run_q, run_d;
  logic [DW-1:0] fix_q;
  logic          set_evt;
  logic          ctrl_en, run_en;

  assign load    = fix_we && ctrl_q.update;
  assign set_evt = tick && !load && (run_q == DW'(1));
  assign ctrl_en = ctrl_we || set_evt;
  assign run_en  = load || tick;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.sel    = ctrl_wdata[3:0];
      ctrl_d.reload = ctrl_wdata[B_RELOAD];
      ctrl_d.update = ctrl_wdata[B_UPDATE];
      ctrl_d.irq_en = ctrl_wdata[B_IRQEN];
      ctrl_d.flag   = ctrl_q.flag & ctrl_wdata[B_FLAG];
    end
    if (set_evt) ctrl_d.flag = 1'b1;
  end

  always_comb begin
    run_d = run_q;
    if (load) begin
      run_d = fix_wdata;
    end else if (tick) begin
      if (run_q != '0)        run_d = run_q - DW'(1);
      else if (ctrl_q.reload) run_d = fix_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q <= '0;
    end else if (fix_we) begin
      fix_q <= fix_wdata;
    end
  end

  assign ctrl    = ctrl_q;
  assign run_cnt = run_q;
  assign fix_cnt = fix_q;
  assign irq     = ctrl_q.flag & ctrl_q.irq_en;

endmodule

// File: rtl/dtimer_top.sv
module dtimer_top #(
  parameter int NCH    = 2,
  parameter int DW     = 32,
  parameter int N_EXT  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_EXT-1:0]  ext_tick,
  input  logic              slow_tick,
  output logic [NCH-1:0]    irq
);
  import dtimer_pkg::*;

  function automatic logic [ADDR_W-1:0] reg_addr(int base, int ch);
    return ADDR_W'(base + ch * CH_STRIDE);
  endfunction

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  ctrl_t [NCH-1:0]          ctrl_v;
  logic  [NCH-1:0][DW-1:0]  run_v;
  logic  [NCH-1:0][DW-1:0]  fix_v;
  logic  [NCH-1:0]          ctrl_we, fix_we, tick_v, load_v;
  logic  [NCH-1:0]          flag_v, en_v, reload_v;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctrl_we[g] = bus_we && (bus_addr == reg_addr(CTRL_OFS, g));
    assign fix_we[g]  = bus_we && (bus_addr == reg_addr(FIX_OFS, g));

    dtimer_tick_sel #(.N_EXT(N_EXT)) u_sel (
      .sel       (ctrl_v[g].sel),
      .ext_tick  (ext_tick),
      .slow_tick (slow_tick),
      .tick      (tick_v[g])
    );

    dtimer_chan #(.DW(DW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .ctrl_we    (ctrl_we[g]),
      .fix_we     (fix_we[g]),
      .ctrl_wdata (bus_wdata[15:0]),
      .fix_wdata  (bus_wdata[DW-1:0]),
      .tick       (tick_v[g]),
      .ctrl       (ctrl_v[g]),
      .run_cnt    (run_v[g]),
      .fix_cnt    (fix_v[g]),
      .load       (load_v[g]),
      .irq        (irq[g])
    );

    assign flag_v[g]   = ctrl_v[g].flag;
    assign en_v[g]     = ctrl_v[g].irq_en;
    assign reload_v[g] = ctrl_v[g].reload;
  end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == reg_addr(CTRL_OFS, n)) bus_rdata = ctrl_pack(ctrl_v[n]);
      if (bus_addr == reg_addr(RUN_OFS, n))  bus_rdata = 32'(run_v[n]);
      if (bus_addr == reg_addr(FIX_OFS, n))  bus_rdata = 32'(fix_v[n]);
    end
  end

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int NCH    = 2,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input logic                     clk,
  input logic                     rst_q_n,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [31:0]              bus_wdata,
  input logic [NCH-1:0][DW-1:0]   run_v,
  input logic [NCH-1:0][DW-1:0]   fix_v,
  input logic [NCH-1:0]           flag_v,
  input logic [NCH-1:0]           en_v,
  input logic [NCH-1:0]           reload_v,
  input logic [NCH-1:0]           tick_v,
  input logic [NCH-1:0]           load_v,
  input logic [NCH-1:0]           ctrl_we,
  input logic [NCH-1:0]           irq
);
  import dtimer_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] RUN_A = ADDR_W'(RUN_OFS + g * CH_STRIDE);

    p_ro_run_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
      (bus_we && bus_addr == RUN_A && !tick_v[g] && !load_v[g]) |=> $stable(run_v[g]));

    p_update_load_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
      load_v[g] |=> run_v[g] == $past(bus_wdata[DW-1:0]));

    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
      (tick_v[g] && !load_v[g] && run_v[g] > DW'(1)) |=> run_v[g] == $past(run_v[g]) - DW'(1));

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (tick_v[g] && !load_v[g] && run_v[g] == DW'(1)) |=> (flag_v[g] && run_v[g] == '0));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (flag_v[g] && !ctrl_we[g]) |=> flag_v[g]);

    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
      (run_v[g] == '0 && !reload_v[g] && !load_v[g]) |=> run_v[g] == '0);

    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
      (run_v[g] == '0 && reload_v[g] && tick_v[g] && !load_v[g]) |=> run_v[g] == $past(fix_v[g]));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
      irq[g] |-> (flag_v[g] && en_v[g]));
  end

endmodule

bind dtimer_top dtimer_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .run_v     (run_v),
  .fix_v     (fix_v),
  .flag_v    (flag_v),
  .en_v      (en_v),
  .reload_v  (reload_v),
  .tick_v    (tick_v),
  .load_v    (load_v),
  .ctrl_we   (ctrl_we),
  .irq       (irq)
);

// File: tb/dtimer_top_tb.sv
module dtimer_top_tb;

  localparam int NCH = 2, DW = 32, N_EXT = 4, ADDR_W = 8;

  typedef struct packed {
    logic [3:0]  sel;
    logic [3:0]  ext;
    logic        slow;
    logic [31:0] exp;
  } vec_t;

  // R5: four held clocks after a load of 100
  localparam vec_t VEC [8] = '{
    '{4'hF, 4'b0000, 1'b0, 32'd96},
    '{4'hB, 4'b0000, 1'b1, 32'd96},
    '{4'hB, 4'b1111, 1'b0, 32'd100},
    '{4'h0, 4'b0001, 1'b0, 32'd96},
    '{4'h2, 4'b0100, 1'b0, 32'd96},
    '{4'h2, 4'b1011, 1'b1, 32'd100},
    '{4'h7, 4'b1111, 1'b1, 32'd100},
    '{4'h3, 4'b1000, 1'b0, 32'd96}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [N_EXT-1:0]  ext_tick;
  logic              slow_tick;
  logic [NCH-1:0]    irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dtimer_top #(.NCH(NCH), .DW(DW), .N_EXT(N_EXT), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .slow_tick(slow_tick), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(int idx);
    ext_tick[idx] = 1'b1;
    @(negedge clk);
    ext_tick = '0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_tick = '0; slow_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h20, v); chk("R1 ctrl0", v, 0);
    rd(8'h30, v); chk("R1 run0", v, 0);
    rd(8'h40, v); chk("R1 fix0", v, 0);
    rd(8'h60, v); chk("R1 ctrl1", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 field layout; R9 writing 1 to flag does not set it
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R2/R9 ctrl readback", v, 32'h0000_40CF);
    rd(8'h10, v); chk("R2 unmapped", v, 0);
    wr(8'h20, 32'h0000_0000);

    // R5 vector table
    foreach (VEC[i]) begin
      wr(8'h20, 32'h80 | 32'(VEC[i].sel));
      wr(8'h40, 32'd100);
      ext_tick = VEC[i].ext; slow_tick = VEC[i].slow;
      repeat (4) @(negedge clk);
      ext_tick = '0; slow_tick = 1'b0;
      rd(8'h30, v); chk($sformatf("R5 vec %0d", i), v, VEC[i].exp);
    end
    wr(8'h20, 32'h0000_0080);

    // R3/R4
    wr(8'h40, 32'h1234);
    rd(8'h30, v); chk("R4 update load", v, 32'h1234);
    wr(8'h30, 32'hDEAD);
    rd(8'h30, v); chk("R3 read-only run", v, 32'h1234);
    wr(8'h20, 32'h0);
    wr(8'h40, 32'h55);
    rd(8'h30, v); chk("R4 no update", v, 32'h1234);
    rd(8'h40, v); chk("R4 fixed stored", v, 32'h55);

    // R6/R7/R10 one-shot
    wr(8'h20, 32'h4080);
    wr(8'h40, 32'd2);
    pulse(0);
    rd(8'h30, v); chk("R6 run 1", v, 1);
    chk("R10 irq low before zero", 32'(irq[0]), 0);
    pulse(0);
    rd(8'h30, v); chk("R6 run 0", v, 0);
    rd(8'h20, v); chk("R6 flag set", v, 32'hC080);
    chk("R10 irq high", 32'(irq[0]), 1);
    pulse(0);
    rd(8'h30, v); chk("R7 hold zero", v, 0);
    rd(8'h20, v); chk("R6 flag sticky", v, 32'hC080);
    wr(8'h20, 32'h8080);
    chk("R10 irq masked", 32'(irq[0]), 0);
    rd(8'h20, v); chk("R9 flag kept by 1", v, 32'h8080);
    wr(8'h20, 32'h0080);
    rd(8'h20, v); chk("R9 flag cleared", v, 32'h0080);

    // R8 reload
    wr(8'h20, 32'h00C0);
    wr(8'h40, 32'd2);
    pulse(0); pulse(0); pulse(0);
    rd(8'h30, v); chk("R8 reloaded", v, 2);
    rd(8'h20, v); chk("R8 flag at zero", v, 32'h80C0);

    // R9 set wins over same-edge clear
    wr(8'h20, 32'h0080);
    wr(8'h40, 32'd1);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0080; ext_tick[0] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ext_tick = '0;
    rd(8'h20, v); chk("R9 set wins", v, 32'h8080);
    rd(8'h30, v); chk("R9 run zero", v, 0);

    // R12 load beats tick
    wr(8'h40, 32'd5);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'd9; ext_tick[0] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ext_tick = '0;
    rd(8'h30, v); chk("R12 load priority", v, 9);

    // R11 channel independence
    rd(8'h30, r0);
    wr(8'h60, 32'h0081);
    wr(8'h80, 32'd7);
    rd(8'h70, v); chk("R11 run1 loaded", v, 7);
    pulse(1);
    rd(8'h70, v); chk("R11 run1 ticked", v, 6);
    rd(8'h30, v); chk("R11 run0 untouched", v, r0);
    rd(8'h40, v); chk("R11 fix0 untouched", v, 9);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule